// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a two-port word memory on a single clock. The left and right ports are symmetric. Each port has an active-low enable, an active-low write select, an active-low output enable, an address, write data, registered read data, an active-low busy input and an active-low interrupt output. Either port can read or write any word at any time. Both ports see the same storage.

The two highest addresses act as mailboxes between the ports. The all-ones address is the right port's receive word. The all-ones-minus-one address is the left port's receive word. A port posts a message by writing the other port's receive word, and this raises the other port's interrupt. The receiving port takes the message by reading its own receive word, and this drops its interrupt. Both mailbox words also keep their data like any other location. A busy input held low by the accessing port stops that access from changing any flag.

The address width and data width are parameters. The default build is small. Setting the address width to 13 and the data width to 16 gives an 8K x 16 array. All port rules mirror between left and right.

Top module: `dpm_mailbox`

## Requirements
- R1: A write is sampled on a clock edge while enable is low and the write select is low. A read is sampled while enable is low, the output enable is low and the write select is high. The read data appears on the port's read-data output after the edge that sampled the read, and that output holds its value in every cycle with no read. Either port reads what either port wrote.
- R2: On a left write to the all-ones address with the left busy input high, the right interrupt output is low (asserted) after that edge.
- R3: On a right write to the all-ones-minus-one address with the right busy input high, the left interrupt output is low after that edge.
- R4: A right access with enable low and output enable low, at the all-ones address and with the right busy input high, drives the right interrupt output high (cleared) after that edge. The write select is ignored for this access.
- R5: A left access with enable low and output enable low, at the all-ones-minus-one address and with the left busy input high, drives the left interrupt output high after that edge. The write select is ignored for this access.
- R6: While the busy input of the accessing port is low, that access neither sets nor clears any interrupt flag. The memory write still takes place.
- R7: While reset is active, both interrupt outputs are high and both read-data outputs are zero.
- R8: Both mailbox words store written data, and a read of either one returns the last value written there.
- R9: A read of the other port's receive word, or a write to a port's own receive word, leaves both interrupt outputs unchanged.
- R10: If one port sets a flag in the same cycle that the other port clears it, the flag ends up set.
- R11: If both ports write the same address in one cycle, the right port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lEnN | input | 1 | Left enable, active low |
| lWrN | input | 1 | Left write select, low = write |
| lOeN | input | 1 | Left output enable, active low |
| lBusyN | input | 1 | Left busy, low blocks flag changes from left accesses |
| lAddr | input | AddrW | Left word address |
| lWrData | input | DataW | Left write data |
| lRdData | output | DataW | Left registered read data |
| lIntN | output | 1 | Left interrupt, active low |
| rEnN | input | 1 | Right enable, active low |
| rWrN | input | 1 | Right write select, low = write |
| rOeN | input | 1 | Right output enable, active low |
| rBusyN | input | 1 | Right busy, low blocks flag changes from right accesses |
| rAddr | input | AddrW | Right word address |
| rWrData | input | DataW | Right write data |
| rRdData | output | DataW | Right registered read data |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The mailbox logic is exercised with several access patterns: a plain write-then-read on each side, a clear made with the write select low, accesses with the busy input low, reads of the wrong port's mailbox, and writes to a port's own receive word. Each pattern separates a correct address-and-direction decode from a design that swaps ports, swaps mailbox words or ignores the busy gate. A same-cycle set and clear tells apart the two possible priorities. Simultaneous writes to different addresses and to the same address check port independence and the collision winner. Idle cycles after a read show whether the read data is held.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Index 0 is the left port and index 1 is the right port in every vector.
  localparam int NumPorts = 2;

  typedef struct packed {
    logic [NumPorts-1:0] wr;      // memory write per port
    logic [NumPorts-1:0] rd;      // memory read per port
    logic [NumPorts-1:0] setInt;  // raise the flag owned by port p
    logic [NumPorts-1:0] clrInt;  // drop the flag owned by port p
  } dpmStrb_t;

endpackage

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic [NumPorts-1:0]       enN,
  input  logic [NumPorts-1:0]       wrN,
  input  logic [NumPorts-1:0]       oeN,
  input  logic [NumPorts-1:0]       busyN,
  input  logic [NumPorts-1:0][AddrW-1:0] addr,
  output dpmStrb_t                  strb
);

  localparam logic [AddrW-1:0] TopAddr = '1;
  localparam logic [AddrW-1:0] NextAddr = TopAddr - 1'b1;

  logic [NumPorts-1:0]             sel;
  logic [NumPorts-1:0]             wrAcc;
  logic [NumPorts-1:0]             oeAcc;
  logic [NumPorts-1:0]             atRx;
  logic [NumPorts-1:0]             atPeerRx;
  logic [NumPorts-1:0][AddrW-1:0]  rxAddr;

  // The left port receives at TopAddr-1 and the right port at TopAddr.
  assign rxAddr[0] = NextAddr;
  assign rxAddr[1] = TopAddr;

  for (genvar gp = 0; gp < NumPorts; gp++) begin : g_port
    localparam int Peer = NumPorts - 1 - gp;

    assign sel[gp]      = ~enN[gp];
    assign wrAcc[gp]    = sel[gp] & ~wrN[gp];
    assign oeAcc[gp]    = sel[gp] & ~oeN[gp];
    assign atRx[gp]     = (addr[gp] == rxAddr[gp]);
    assign atPeerRx[gp] = (addr[gp] == rxAddr[Peer]);

    assign strb.wr[gp]  = wrAcc[gp];
    assign strb.rd[gp]  = oeAcc[gp] & wrN[gp];

    // A flag is raised by a write from the peer into this port's receive word.
    assign strb.setInt[gp] = wrAcc[Peer] & atPeerRx[Peer] & busyN[Peer];
    // A flag is dropped by this port reading its own receive word.
    assign strb.clrInt[gp] = oeAcc[gp] & atRx[gp] & busyN[gp];
  end

endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  dpmStrb_t                       strb,
  input  logic [NumPorts-1:0][AddrW-1:0] addr,
  input  logic [NumPorts-1:0][DataW-1:0] wrData,
  output logic [NumPorts-1:0][DataW-1:0] rdData,
  output logic [NumPorts-1:0]            intN
);

  localparam int Depth = 1 << AddrW;

  logic [DataW-1:0]    mem [Depth];
  logic [NumPorts-1:0] flagQ;

  // Port order in this block makes the right port win a same-address collision.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NumPorts; p++) begin
      if (strb.wr[p]) mem[addr[p]] <= wrData[p];
    end
  end

  for (genvar gp = 0; gp < NumPorts; gp++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdData[gp] <= '0;
      end else if (strb.rd[gp]) begin
        rdData[gp] <= mem[addr[gp]];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flagQ[gp] <= 1'b0;
      end else if (strb.setInt[gp]) begin
        flagQ[gp] <= 1'b1;
      end else if (strb.clrInt[gp]) begin
        flagQ[gp] <= 1'b0;
      end
    end

    assign intN[gp] = ~flagQ[gp];
  end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lEnN,
  input  logic             lWrN,
  input  logic             lOeN,
  input  logic             lBusyN,
  input  logic [AddrW-1:0] lAddr,
  input  logic [DataW-1:0] lWrData,
  output logic [DataW-1:0] lRdData,
  output logic             lIntN,
  input  logic             rEnN,
  input  logic             rWrN,
  input  logic             rOeN,
  input  logic             rBusyN,
  input  logic [AddrW-1:0] rAddr,
  input  logic [DataW-1:0] rWrData,
  output logic [DataW-1:0] rRdData,
  output logic             rIntN
);

  dpmStrb_t                       strb;
  logic [NumPorts-1:0][AddrW-1:0] addrV;
  logic [NumPorts-1:0][DataW-1:0] wrDataV;
  logic [NumPorts-1:0][DataW-1:0] rdDataV;
  logic [NumPorts-1:0]            intNV;

  assign addrV   = {rAddr, lAddr};
  assign wrDataV = {rWrData, lWrData};

  dpm_ctrl #(.AddrW(AddrW)) i_ctrl (
    .enN   ({rEnN, lEnN}),
    .wrN   ({rWrN, lWrN}),
    .oeN   ({rOeN, lOeN}),
    .busyN ({rBusyN, lBusyN}),
    .addr  (addrV),
    .strb  (strb)
  );

  dpm_datapath #(.AddrW(AddrW), .DataW(DataW)) i_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .addr   (addrV),
    .wrData (wrDataV),
    .rdData (rdDataV),
    .intN   (intNV)
  );

  assign lRdData = rdDataV[0];
  assign rRdData = rdDataV[1];
  assign lIntN   = intNV[0];
  assign rIntN   = intNV[1];

endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lEnN,
  input logic             lWrN,
  input logic             lOeN,
  input logic             lBusyN,
  input logic [AddrW-1:0] lAddr,
  input logic [DataW-1:0] lWrData,
  input logic [DataW-1:0] lRdData,
  input logic             lIntN,
  input logic             rEnN,
  input logic             rWrN,
  input logic             rOeN,
  input logic             rBusyN,
  input logic [AddrW-1:0] rAddr,
  input logic [DataW-1:0] rWrData,
  input logic [DataW-1:0] rRdData,
  input logic             rIntN
);

  localparam logic [AddrW-1:0] TopAddr = '1;
  localparam logic [AddrW-1:0] NextAddr = TopAddr - 1'b1;

  logic postToR, postToL, takeR, takeL;
  assign postToR = !lEnN && !lWrN && (lAddr == TopAddr) && lBusyN;
  assign postToL = !rEnN && !rWrN && (rAddr == NextAddr) && rBusyN;
  assign takeR   = !rEnN && !rOeN && (rAddr == TopAddr) && rBusyN;
  assign takeL   = !lEnN && !lOeN && (lAddr == NextAddr) && lBusyN;

  // R7
  p_reset_quiet_r7: assert property (@(posedge clk) !rst_n |=> (lIntN && rIntN));

  p_post_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    postToR |=> !rIntN);

  p_post_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    postToL |=> !lIntN);

  p_take_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (takeR && !postToR) |=> rIntN);

  p_take_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (takeL && !postToL) |=> lIntN);

  p_busy_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lBusyN && !postToL) |=> $stable(lIntN));

  p_busy_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rBusyN && !postToR) |=> $stable(rIntN));

  p_hold_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lEnN && !lOeN && lWrN) |=> $stable(lRdData));

  p_hold_right_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rEnN && !rOeN && rWrN) |=> $stable(rRdData));

endmodule

bind dpm_mailbox dpm_mailbox_chk #(.AddrW(AddrW), .DataW(DataW)) i_chk (.*);

// File: tb/test_dpm_mailbox.sv
module test_dpm_mailbox;

  localparam int AddrW = 11;
  localparam int DataW = 16;
  localparam logic [AddrW-1:0] TopAddr = '1;
  localparam logic [AddrW-1:0] NextAddr = TopAddr - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lEnN = 1'b1, lWrN = 1'b1, lOeN = 1'b1, lBusyN = 1'b1;
  logic rEnN = 1'b1, rWrN = 1'b1, rOeN = 1'b1, rBusyN = 1'b1;
  logic [AddrW-1:0] lAddr = '0, rAddr = '0;
  logic [DataW-1:0] lWrData = '0, rWrData = '0;
  logic [DataW-1:0] lRdData, rRdData;
  logic lIntN, rIntN;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  dpm_mailbox #(.AddrW(AddrW), .DataW(DataW)) i_dpm_mailbox (.*);

  task automatic chk(input string req, input logic [DataW-1:0] act, input logic [DataW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance one edge and sample 2 ns after it.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    lEnN = 1'b1; lWrN = 1'b1; lOeN = 1'b1; lBusyN = 1'b1;
    rEnN = 1'b1; rWrN = 1'b1; rOeN = 1'b1; rBusyN = 1'b1;
  endtask

  task automatic driveL(input logic wr, input logic oe, input logic [AddrW-1:0] a,
                        input logic [DataW-1:0] d, input logic busy);
    lEnN = 1'b0; lWrN = ~wr; lOeN = ~oe; lAddr = a; lWrData = d; lBusyN = busy;
  endtask

  task automatic driveR(input logic wr, input logic oe, input logic [AddrW-1:0] a,
                        input logic [DataW-1:0] d, input logic busy);
    rEnN = 1'b0; rWrN = ~wr; rOeN = ~oe; rAddr = a; rWrData = d; rBusyN = busy;
  endtask

  task automatic t_reset();
    chk("R7 lIntN", {15'd0, lIntN}, 16'd1);
    chk("R7 rIntN", {15'd0, rIntN}, 16'd1);
    chk("R7 lRdData", lRdData, 16'h0000);
    chk("R7 rRdData", rRdData, 16'h0000);
  endtask

  task automatic t_storage();
    driveL(1, 0, 11'h010, 16'hA5A5, 1); step(); idle();
    driveR(0, 1, 11'h010, 16'h0, 1); step(); idle();
    chk("R1 cross read", rRdData, 16'hA5A5);
    driveL(1, 0, 11'h020, 16'h1111, 1);
    driveR(1, 0, 11'h021, 16'h2222, 1); step(); idle();
    driveL(0, 1, 11'h021, 16'h0, 1);
    driveR(0, 1, 11'h020, 16'h0, 1); step(); idle();
    chk("R1 left reads right", lRdData, 16'h2222);
    chk("R1 right reads left", rRdData, 16'h1111);
    step(); step();
    chk("R1 hold", rRdData, 16'h1111);
  endtask

  task automatic t_rightMailbox();
    driveL(1, 0, TopAddr, 16'h1234, 1); step(); idle();
    chk("R2 set right", {15'd0, rIntN}, 16'd0);
    chk("R2 left untouched", {15'd0, lIntN}, 16'd1);
    driveR(0, 1, TopAddr, 16'h0, 1); step(); idle();
    chk("R4 clear right", {15'd0, rIntN}, 16'd1);
    chk("R8 right mailbox data", rRdData, 16'h1234);
    // clear with write select low: this access also writes the word
    driveL(1, 0, TopAddr, 16'h5555, 1); step(); idle();
    chk("R2 set again", {15'd0, rIntN}, 16'd0);
    driveR(1, 1, TopAddr, 16'h9999, 1); step(); idle();
    chk("R4 clear ignores write select", {15'd0, rIntN}, 16'd1);
    driveL(0, 1, TopAddr, 16'h0, 1); step(); idle();
    chk("R8 last write kept", lRdData, 16'h9999);
    chk("R9 peer word read no change", {15'd0, rIntN}, 16'd1);
    chk("R9 left flag no change", {15'd0, lIntN}, 16'd1);
  endtask

  task automatic t_leftMailbox();
    driveR(1, 0, NextAddr, 16'hBEEF, 1); step(); idle();
    chk("R3 set left", {15'd0, lIntN}, 16'd0);
    chk("R3 right untouched", {15'd0, rIntN}, 16'd1);
    driveL(0, 1, NextAddr, 16'h0, 1); step(); idle();
    chk("R5 clear left", {15'd0, lIntN}, 16'd1);
    chk("R8 left mailbox data", lRdData, 16'hBEEF);
  endtask

  task automatic t_busy();
    driveL(1, 0, TopAddr, 16'h7777, 0); step(); idle();
    chk("R6 busy blocks set", {15'd0, rIntN}, 16'd1);
    driveR(0, 1, TopAddr, 16'h0, 1); step(); idle();
    chk("R6 write still lands", rRdData, 16'h7777);
    driveR(1, 0, NextAddr, 16'h0101, 1); step(); idle();
    chk("R3 set for busy test", {15'd0, lIntN}, 16'd0);
    driveL(0, 1, NextAddr, 16'h0, 0); step(); idle();
    chk("R6 busy blocks clear", {15'd0, lIntN}, 16'd0);
    driveL(0, 1, NextAddr, 16'h0, 1); step(); idle();
    chk("R5 clear after busy", {15'd0, lIntN}, 16'd1);
  endtask

  task automatic t_ownWord();
    driveL(1, 0, NextAddr, 16'h4242, 1); step(); idle();
    chk("R9 own receive write left", {15'd0, lIntN}, 16'd1);
    chk("R9 own receive write right", {15'd0, rIntN}, 16'd1);
    driveR(1, 0, TopAddr, 16'h4343, 1); step(); idle();
    chk("R9 right own word write", {15'd0, rIntN}, 16'd1);
    chk("R9 right own word write, left", {15'd0, lIntN}, 16'd1);
    driveR(0, 1, NextAddr, 16'h0, 1); step(); idle();
    chk("R9 right reads peer word", {15'd0, lIntN}, 16'd1);
    chk("R8 data at receive word", rRdData, 16'h4242);
  endtask

  task automatic t_race();
    driveL(1, 0, TopAddr, 16'hAAAA, 1);
    driveR(0, 1, TopAddr, 16'h0, 1); step(); idle();
    chk("R10 set wins from clear", {15'd0, rIntN}, 16'd0);
    driveR(1, 0, NextAddr, 16'hCCCC, 1);
    driveL(0, 1, NextAddr, 16'h0, 1); step(); idle();
    chk("R10 set wins left", {15'd0, lIntN}, 16'd0);
    driveR(0, 1, TopAddr, 16'h0, 1);
    driveL(0, 1, NextAddr, 16'h0, 1); step(); idle();
    chk("R4 clear after race", {15'd0, rIntN}, 16'd1);
    chk("R5 clear after race", {15'd0, lIntN}, 16'd1);
  endtask

  task automatic t_collide();
    driveL(1, 0, 11'h030, 16'h0F0F, 1);
    driveR(1, 0, 11'h030, 16'hF0F0, 1); step(); idle();
    driveL(0, 1, 11'h030, 16'h0, 1); step(); idle();
    chk("R11 right wins collision", lRdData, 16'hF0F0);
  endtask

  initial begin
    idle();
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    step();
    t_storage();
    t_rightMailbox();
    t_leftMailbox();
    t_busy();
    t_ownWord();
    t_race();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 20000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule